// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control of a three-phase integrating converter. It runs from the free-running oscillator, divides it by four into a count tick, and steps through three phases: auto-zero, signal integration and reference integration. In each phase it raises one analog switch-select output. The analog integrator, comparator and switches are outside the block. The only analog-side input is the comparator, which reports whether the integrator output is above zero.

The signal phase has a fixed length. At its last count the comparator level gives the sign of the input. The reference phase then applies the reference with the opposite polarity and counts ticks in a four-digit BCD counter. It stops at the first count where the comparator shows that the integrator has crossed back through zero. The count reached is the reading. It is latched to the outputs together with the sign and an overrange flag, and a one-cycle strobe marks it. Auto-zero takes up whatever reference time went unused, so a full measurement always takes the same number of counts.

The state machine has three states. `PH_AUTOZERO` moves to `PH_SIGNAL` when the planned auto-zero length has elapsed. `PH_SIGNAL` moves to `PH_DEINT` after the fixed signal length and captures the sign on that move. `PH_DEINT` returns to `PH_AUTOZERO` on a zero crossing or on reaching the count limit, and on that return it latches the result and plans the next auto-zero length.

Top module: `dsadc_sequencer`

## Requirements
- R1: A count tick occurs on every fourth oscillator cycle (PRESCALE), counted from reset release. Phase changes happen only at a tick, so every phase lasts a whole number of counts, each PRESCALE oscillator cycles long.
- R2: The signal phase (`sw_signal` high) lasts exactly SIG_COUNTS counts (default 1000).
- R3: The reference phase ends at the first count whose synchronised comparator level equals the captured negative-sign bit, meaning the integrator has crossed. If that first count is the k-th (k from 0), the reading is k and the phase has lasted k+1 counts. The comparator passes through two flip-flops, so a change made one oscillator cycle after a count boundary takes effect at the next boundary.
- R4: A full measurement (auto-zero + signal + reference) always lasts CYCLE_COUNTS counts (default 4000), whatever the reading.
- R5: Auto-zero lasts CYCLE_COUNTS − SIG_COUNTS − (reference-phase length) counts, so it falls between 1000 and 2999 counts by default. The first auto-zero after reset takes the minimum, CYCLE_COUNTS − SIG_COUNTS − MAX_DEINT.
- R6: The sign is captured at the last signal count. Comparator low (integrator not above zero) gives `rd_negative` = 1. Comparator high gives 0.
- R7: During the reference phase, `sw_ref_neg` is high for a positive capture and `sw_ref_pos` is high for a negative capture. Exactly one of them is high, and it does not change within the phase.
- R8: If no crossing is seen in MAX_DEINT counts (default 2000), `rd_overrange` = 1 and the reading is held at MAX_DEINT − 1 (1999). A crossing seen on the last allowed count gives that same reading with `rd_overrange` = 0.
- R9: `rd_bcd` is packed BCD: [15:12] thousands (0 or 1 only), [11:8] hundreds, [7:4] tens, [3:0] units. Every digit stays at 9 or below.
- R10: `rd_valid` pulses high for one oscillator cycle, on the edge where the reference phase ends. `rd_bcd`, `rd_negative` and `rd_overrange` change only on that edge and hold until the next one.
- R11: While reset is asserted, `sw_autozero` = 1, the other switch selects are 0, `rd_valid` = 0 and the result outputs are 0. The sequencer starts in auto-zero with the count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all state is clocked by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| comp_in | input | 1 | Comparator: 1 when integrator output is above zero (asynchronous) |
| sw_autozero | output | 1 | Select auto-zero switch network |
| sw_signal | output | 1 | Select input-signal switch network |
| sw_ref_pos | output | 1 | Apply reference with positive polarity |
| sw_ref_neg | output | 1 | Apply reference with negative polarity |
| rd_bcd | output | 16 | Latched reading, four packed BCD digits |
| rd_negative | output | 1 | Latched sign, 1 for negative input |
| rd_overrange | output | 1 | Latched overrange flag |
| rd_valid | output | 1 | One-cycle strobe for a new result |

## Verification
Assertions check on every cycle that the state moves only on a count tick and that ticks never fall on adjacent cycles. They also check the BCD digit range, including the top digit limit, and that the planned auto-zero length stays within its bounds. Further assertions cover the one-cycle strobe, holding of the result between strobes, the clamp value under overrange, and a steady reference polarity within a phase. The bench scenarios show what only end-to-end timing can: the exact reading produced by a comparator crossing at each count position. They also show the length of each phase, the constant total cycle length, correct sign capture for both polarities, and the crossing-versus-limit corner at the last count.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        PH_AUTOZERO = 2'd0,
        PH_SIGNAL   = 2'd1,
        PH_DEINT    = 2'd2
    } phase_e;

    // Packs a small integer into four BCD digits (used for constants).
    function automatic logic [15:0] bcd_of(input int unsigned v);
        logic [15:0]  res;
        int unsigned  rem;
        rem = v;
        res = '0;
        for (int i = 0; i < 4; i++) begin
            res[4*i +: 4] = 4'(rem % 10);
            rem = rem / 10;
        end
        return res;
    endfunction

endpackage

// File: rtl/dsadc_prescaler.sv
module dsadc_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] div_q;

    assign tick = (div_q == PW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     div_q <= '0;
        else if (tick)  div_q <= '0;
        else            div_q <= div_q + PW'(1);
    end

    // Ticks are never back to back: one count spans DIV oscillator cycles.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dsadc_sync2.sv
module dsadc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/dsadc_bcd_count.sv
module dsadc_bcd_count #(
    parameter int unsigned DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS-1:0] cin;

    assign cin[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig_q;

        if (g < DIGITS - 1) begin : g_link
            assign cin[g+1] = cin[g] && (dig_q == 4'd9);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dig_q <= 4'd0;
            else if (clr)     dig_q <= 4'd0;
            else if (cin[g])  dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
        end

        assign value[4*g +: 4] = dig_q;

        p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q <= 4'd9);
    end

endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int unsigned PRESCALE     = 4,
    parameter int unsigned SIG_COUNTS   = 1000,
    parameter int unsigned MAX_DEINT    = 2000,
    parameter int unsigned CYCLE_COUNTS = 4000
) (
    input  logic        clk_osc,
    input  logic        rst_n,
    input  logic        comp_in,
    output logic        sw_autozero,
    output logic        sw_signal,
    output logic        sw_ref_pos,
    output logic        sw_ref_neg,
    output logic [15:0] rd_bcd,
    output logic        rd_negative,
    output logic        rd_overrange,
    output logic        rd_valid
);
    localparam int unsigned DIGITS    = 4;
    localparam int unsigned CW        = $clog2(CYCLE_COUNTS + 1);
    localparam int unsigned AZ_SHARE  = CYCLE_COUNTS - SIG_COUNTS;   // auto-zero + reference
    localparam int unsigned AZ_MIN    = AZ_SHARE - MAX_DEINT;
    localparam logic [15:0] LIMIT_BCD = bcd_of(MAX_DEINT - 1);

    phase_e          st;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   az_len;
    logic            sign_neg;
    logic            tick;
    logic            comp_s;
    logic [15:0]     bcd_val;
    logic            bcd_clr, bcd_inc;
    logic            az_last, sig_last, at_limit, crossed;

    dsadc_prescaler #(.DIV(PRESCALE)) u_prescale (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dsadc_sync2 u_comp_sync (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .d     (comp_in),
        .q     (comp_s)
    );

    dsadc_bcd_count #(.DIGITS(DIGITS)) u_reading (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .clr   (bcd_clr),
        .inc   (bcd_inc),
        .value (bcd_val)
    );

    assign az_last  = (cnt == az_len - CW'(1));
    assign sig_last = (cnt == CW'(SIG_COUNTS - 1));
    assign at_limit = (cnt == CW'(MAX_DEINT - 1));
    assign crossed  = (comp_s == sign_neg);

    assign bcd_clr = tick && (st == PH_SIGNAL) && sig_last;
    assign bcd_inc = tick && (st == PH_DEINT) && !crossed && !at_limit;

    // State register, phase counter, sign capture and result latch.
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            st           <= PH_AUTOZERO;
            cnt          <= '0;
            az_len       <= CW'(AZ_MIN);
            sign_neg     <= 1'b0;
            rd_bcd       <= '0;
            rd_negative  <= 1'b0;
            rd_overrange <= 1'b0;
            rd_valid     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (tick) begin
                unique case (st)
                    PH_AUTOZERO: begin
                        if (az_last) begin
                            st  <= PH_SIGNAL;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    PH_SIGNAL: begin
                        if (sig_last) begin
                            st       <= PH_DEINT;
                            cnt      <= '0;
                            sign_neg <= ~comp_s;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    PH_DEINT: begin
                        if (crossed || at_limit) begin
                            st           <= PH_AUTOZERO;
                            cnt          <= '0;
                            az_len       <= CW'(AZ_SHARE) - cnt - CW'(1);
                            rd_bcd       <= bcd_val;
                            rd_negative  <= sign_neg;
                            rd_overrange <= !crossed;
                            rd_valid     <= 1'b1;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: begin
                        st  <= PH_AUTOZERO;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    // Switch-select decode.
    always_comb begin
        sw_autozero = 1'b0;
        sw_signal   = 1'b0;
        sw_ref_pos  = 1'b0;
        sw_ref_neg  = 1'b0;
        unique case (st)
            PH_AUTOZERO: sw_autozero = 1'b1;
            PH_SIGNAL:   sw_signal   = 1'b1;
            PH_DEINT: begin
                if (sign_neg) sw_ref_pos = 1'b1;
                else          sw_ref_neg = 1'b1;
            end
            default:     sw_autozero = 1'b1;
        endcase
    end

    p_phase_on_tick_r1: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !tick |=> $stable(st));

    p_az_bounds_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (az_len >= CW'(AZ_MIN)) && (az_len <= CW'(AZ_SHARE - 1)));

    p_ref_steady_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ((sw_ref_pos || sw_ref_neg) && $past(sw_ref_pos || sw_ref_neg))
            |-> $stable(sw_ref_pos));

    p_clamp_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (rd_valid && rd_overrange) |-> (rd_bcd == LIMIT_BCD));

    p_top_digit_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (bcd_val[15:12] <= 4'd1) && (rd_bcd[15:12] <= 4'd1));

    p_strobe_once_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_result_hold_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !rd_valid |-> ($stable(rd_bcd) && $stable(rd_negative) && $stable(rd_overrange)));

endmodule

// File: tb/dsadc_sequencer_tb_top.sv
module dsadc_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam int SIG        = 40;
    localparam int MAXD       = 120;
    localparam int CYC        = 200;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        comp_in;
    logic        sw_autozero, sw_signal, sw_ref_pos, sw_ref_neg;
    logic [15:0] rd_bcd;
    logic        rd_negative, rd_overrange, rd_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsadc_sequencer #(
        .PRESCALE     (PRE),
        .SIG_COUNTS   (SIG),
        .MAX_DEINT    (MAXD),
        .CYCLE_COUNTS (CYC)
    ) dut_i (
        .clk_osc      (clk),
        .rst_n        (rst_n),
        .comp_in      (comp_in),
        .sw_autozero  (sw_autozero),
        .sw_signal    (sw_signal),
        .sw_ref_pos   (sw_ref_pos),
        .sw_ref_neg   (sw_ref_neg),
        .rd_bcd       (rd_bcd),
        .rd_negative  (rd_negative),
        .rd_overrange (rd_overrange),
        .rd_valid     (rd_valid)
    );

    function automatic int to_bcd(input int v);
        return (v / 1000) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Entered at a negedge with sw_signal high; returns at the negedge
    // where the following signal phase is first seen.
    task automatic run_cycle(input bit neg, input int k);
        int sig_len, ref_len, az_len, exp_cnt, held;
        bit exp_ovr;
        comp_in = !neg;
        sig_len = 0;
        while (sw_signal) begin
            sig_len++;
            @(negedge clk);
        end
        chk(sig_len == PRE * SIG, "R2", "signal phase osc cycles (R1)", sig_len, PRE * SIG);
        if (neg)
            chk(sw_ref_pos && !sw_ref_neg, "R7", "negative capture selects pos ref",
                int'(sw_ref_pos), 1);
        else
            chk(sw_ref_neg && !sw_ref_pos, "R7", "positive capture selects neg ref",
                int'(sw_ref_neg), 1);
        ref_len = 0;
        while (sw_ref_pos || sw_ref_neg) begin
            if (ref_len == PRE * k) comp_in = neg;
            ref_len++;
            @(negedge clk);
        end
        exp_cnt = (k < MAXD) ? k : MAXD - 1;
        exp_ovr = (k >= MAXD);
        chk(ref_len == PRE * (exp_cnt + 1), "R3", "reference phase osc cycles",
            ref_len, PRE * (exp_cnt + 1));
        chk(rd_valid == 1'b1, "R10", "strobe at phase end", int'(rd_valid), 1);
        chk(int'(rd_bcd) == to_bcd(exp_cnt), "R3", "reading in BCD (R9)",
            int'(rd_bcd), to_bcd(exp_cnt));
        chk(rd_negative == neg, "R6", "captured sign", int'(rd_negative), int'(neg));
        chk(rd_overrange == exp_ovr, "R8", "overrange flag", int'(rd_overrange), int'(exp_ovr));
        held = int'(rd_bcd);
        az_len = 1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10", "strobe lasts one cycle", int'(rd_valid), 0);
        while (sw_autozero) begin
            az_len++;
            @(negedge clk);
        end
        chk(az_len == PRE * (CYC - SIG - (exp_cnt + 1)), "R5", "auto-zero osc cycles",
            az_len, PRE * (CYC - SIG - (exp_cnt + 1)));
        chk(sig_len + ref_len + az_len == PRE * CYC, "R4", "full measurement osc cycles",
            sig_len + ref_len + az_len, PRE * CYC);
        chk(int'(rd_bcd) == held, "R10", "reading held until next strobe", int'(rd_bcd), held);
    endtask

    initial begin
        int az0;
        rst_n   = 1'b0;
        comp_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(sw_autozero == 1'b1, "R11", "reset auto-zero select", int'(sw_autozero), 1);
        chk({sw_signal, sw_ref_pos, sw_ref_neg} == 3'b000, "R11", "reset other selects",
            int'({sw_signal, sw_ref_pos, sw_ref_neg}), 0);
        chk(rd_valid == 1'b0, "R11", "reset strobe", int'(rd_valid), 0);
        chk({rd_bcd, rd_negative, rd_overrange} == 18'd0, "R11", "reset result",
            int'({rd_bcd, rd_negative, rd_overrange}), 0);
        rst_n = 1'b1;
        az0 = 0;
        while (sw_autozero) begin
            az0++;
            @(negedge clk);
        end
        chk(az0 == PRE * (CYC - SIG - MAXD), "R5", "first auto-zero after reset",
            az0, PRE * (CYC - SIG - MAXD));
        for (int k = 0; k <= MAXD + 1; k++) run_cycle(1'b0, k);
        for (int k = 0; k <= MAXD; k += 4) run_cycle(1'b1, k);
        run_cycle(1'b1, MAXD - 1);
        run_cycle(1'b1, MAXD + 3);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule